// File: doc/BRIEF.md
# Dead-Band Generator with Kill

This block turns one PWM-style input into two complementary drive outputs that are never high together. Whenever the input changes level, both drives go low at once. A down-counter then measures a programmable dead time, and the drive that matches the new input level is switched on when the counter expires. `f0` follows the high level of the input and `f1` follows the low level. The input comes straight from a neighbouring PWM that runs on the same clock, so it is treated as synchronous.

Two register strobes program the block. One strobe sets the enable flag. The other writes the dead-time period. While the block is disabled it is frozen: both drives and the interrupt are low, and a period write also loads the counter, which sets up the next dead time. An asynchronous kill input passes through a flip-flop synchroniser and then gates both drives low. It leaves the sequencing untouched, so counting and the interrupt continue while kill is high. An interrupt pulse marks the end of each dead time. The counter value is brought out so that it can be observed.

The controller has three states. `S_OFF` means disabled. `S_DEAD` means a dead time is being counted. `S_DRIVE` means one drive is on. The transitions are:
- OFF→DEAD when the enable flag is set.
- DEAD→DRIVE when the counter is zero and the input has not changed.
- DRIVE→DEAD and DEAD→DEAD (restart) on an input edge.
- Any state→OFF when the enable flag is cleared.

Top module: `deadband_gen`

## Requirements
- R1: After reset, `f0`, `f1` and `irq` are 0, `dead_cnt` is 0, the block is disabled and the period is 0.
- R2: While disabled (`S_OFF`), `f0`, `f1` and `irq` stay 0 whatever `pwm_in` does.
- R3: A period write (`per_wr`) while disabled also loads `per_wdata` into the counter, visible on `dead_cnt` one clock later.
- R4: A period write while enabled changes only the stored period. `dead_cnt` is unaffected until the next input edge reloads it.
- R5: An input change seen at clock edge t reloads the counter with the period and forces both drives low after edge t, even in the middle of a dead time (restart).
- R6: With period P and no further input change, the drive for the new level rises after edge t+P+1. `f0` is driven when the input is 1 and `f1` when it is 0. The counter steps down by one per clock from P to 0.
- R7: `f0` and `f1` are never 1 together.
- R8: `irq` is a one-clock pulse, high in the same cycle in which a drive turns on after a dead time.
- R9: Kill goes through a two-flop synchroniser. After `kill_in` rises, the drives are low from the second clock edge on. After it falls, they follow the controller again from the second edge. The counter and `irq` are unaffected by kill.
- R10: `ctl_wr` with `ctl_enable`=1 sets the enable flag at edge e. The controller enters `S_DEAD` at e+1 and counts down from the counter's current value C. The drive for the present input level rises after edge e+C+2.
- R11: `ctl_wr` with `ctl_enable`=0 clears the enable flag. From the following edge the counter holds its value and the controller is in `S_OFF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_enable | input | 1 | Enable value written on `ctl_wr` (1 = run) |
| per_wr | input | 1 | Period write strobe |
| per_wdata | input | CNT_W | Dead-time period value |
| pwm_in | input | 1 | PWM input from the neighbouring block |
| kill_in | input | 1 | Asynchronous kill, active high |
| f0 | output | 1 | Drive active while input is high |
| f1 | output | 1 | Drive active while input is low |
| irq | output | 1 | One-clock pulse at the end of each dead time |
| dead_cnt | output | CNT_W | Current counter value |

## Verification
The bench targets several corner cases, each with a distinct failure it would expose:
- An input edge that arrives mid-count: a design that does not restart would switch a drive on too early, before the full dead time.
- A period of zero, where the drive must still wait one clock: an off-by-one here would either overlap the drives or drop the interrupt.
- Period writes in both modes: if a write while enabled leaked into the counter, the running dead time would change.
- Kill while a dead time expires: a design that let kill touch the sequencing would lose the interrupt or resume in the wrong state.
- Disabling in the middle of a count: the counter must freeze rather than keep running or reload.

// File: rtl/db_pkg.sv
package db_pkg;
    typedef enum logic [1:0] {
        S_OFF   = 2'd0,
        S_DEAD  = 2'd1,
        S_DRIVE = 2'd2
    } db_state_e;
endpackage

// File: rtl/db_kill_sync.sv
module db_kill_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], din};
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/db_counter.sv
module db_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R6: a decrement never wraps the counter below zero
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> (cnt != {CNT_W{1'b1}}));
endmodule

// File: rtl/deadband_gen.sv
module deadband_gen #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_enable,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic             pwm_in,
    input  logic             kill_in,
    output logic             f0,
    output logic             f1,
    output logic             irq,
    output logic [CNT_W-1:0] dead_cnt
);
    import db_pkg::*;

    db_state_e        state_q, state_n;
    logic             en_q;
    logic [CNT_W-1:0] per_q;
    logic             in_prev_q;
    logic             lvl_q;
    logic             irq_q;
    logic             kill_s;
    logic             in_edge;
    logic             cnt_zero;
    logic             cnt_load;
    logic             cnt_dec;
    logic [CNT_W-1:0] cnt_load_val;
    logic             expire;

    db_kill_sync #(.STAGES(SYNC_STAGES)) u_kill (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (kill_in),
        .dout (kill_s)
    );

    assign in_edge = pwm_in ^ in_prev_q;
    assign expire  = en_q && (state_q == S_DEAD) && !in_edge && cnt_zero;

    // Counter control: disabled period write, or edge reload while running
    always_comb begin
        cnt_load     = 1'b0;
        cnt_load_val = per_q;
        cnt_dec      = 1'b0;
        if (!en_q) begin
            cnt_load     = per_wr;
            cnt_load_val = per_wdata;
        end else if (state_q != S_OFF && in_edge) begin
            cnt_load = 1'b1;
        end else if (state_q == S_DEAD && !cnt_zero) begin
            cnt_dec = 1'b1;
        end
    end

    db_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_load_val),
        .dec     (cnt_dec),
        .cnt     (dead_cnt),
        .zero    (cnt_zero)
    );

    // Registers written through the strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            per_q <= '0;
        end else begin
            if (ctl_wr) en_q  <= ctl_enable;
            if (per_wr) per_q <= per_wdata;
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        if (!en_q) begin
            state_n = S_OFF;
        end else begin
            unique case (state_q)
                S_OFF:   state_n = S_DEAD;
                S_DEAD:  state_n = in_edge ? S_DEAD : (cnt_zero ? S_DRIVE : S_DEAD);
                S_DRIVE: state_n = in_edge ? S_DEAD : S_DRIVE;
                default: state_n = S_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_OFF;
            in_prev_q <= 1'b0;
            lvl_q     <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            state_q   <= state_n;
            in_prev_q <= pwm_in;
            irq_q     <= expire;
            if (expire) lvl_q <= pwm_in;
        end
    end

    // Outputs: kill gates the registered drive
    always_comb begin
        f0  = (state_q == S_DRIVE) &&  lvl_q && !kill_s;
        f1  = (state_q == S_DRIVE) && !lvl_q && !kill_s;
        irq = irq_q;
    end

    // R2: disabled block is silent
    a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OFF) |-> (!f0 && !f1 && !irq));
    // R3: period write while disabled lands in the counter
    a_r3_off_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && per_wr) |=> (dead_cnt == $past(per_wdata)));
    // R7: drives never overlap
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(f0 && f1));
    // R8: interrupt is a single cycle and coincides with drive state
    a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    a_r8_irq_drive: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (state_q == S_DRIVE));
    // R9: synchronised kill holds both drives low
    a_r9_kill_low: assert property (@(posedge clk) disable iff (!rst_n)
        kill_s |-> (!f0 && !f1));
    // R11: once disabled, counter is frozen unless a period write occurs
    a_r11_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OFF && !en_q && !per_wr) |=> $stable(dead_cnt));
endmodule

// File: tb/deadband_gen_test.sv
module deadband_gen_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ctl_wr = 1'b0;
    logic         ctl_enable = 1'b0;
    logic         per_wr = 1'b0;
    logic [W-1:0] per_wdata = '0;
    logic         pwm_in = 1'b0;
    logic         kill_in = 1'b0;
    logic         f0, f1, irq;
    logic [W-1:0] dead_cnt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    deadband_gen #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_enable(ctl_enable),
        .per_wr(per_wr), .per_wdata(per_wdata), .pwm_in(pwm_in),
        .kill_in(kill_in), .f0(f0), .f1(f1), .irq(irq), .dead_cnt(dead_cnt)
    );

    always #2.5 clk = ~clk;

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_period(input int p);
        per_wr = 1'b1; per_wdata = W'(p);
        tick();
        per_wr = 1'b0;
    endtask

    // Remaining part of a dead time: counter at p, P ticks low, then rise
    task automatic finish_dead(input logic lvl, input int p, input bit killed);
        check("R5 both low after edge", int'({f0, f1}), 0);
        check("R6 counter start", int'(dead_cnt), p);
        for (int i = 0; i < p; i++) begin
            tick();
            check("R7 low during dead time", int'({f0, f1}), 0);
            check("R6 counter step", int'(dead_cnt), p - 1 - i);
        end
        tick();
        check("R8 irq at rise", int'(irq), 1);
        if (killed) check("R9 killed drive low", int'({f0, f1}), 0);
        else        check("R6 drive for level", int'({f0, f1}), lvl ? 2 : 1);
        tick();
        check("R8 irq single cycle", int'(irq), 0);
    endtask

    task automatic edge_run(input logic lvl, input int p, input bit killed);
        pwm_in = lvl;
        tick();
        finish_dead(lvl, p, killed);
    endtask

    task automatic t_reset;
        check("R1 f0/f1", int'({f0, f1}), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 counter", int'(dead_cnt), 0);
    endtask

    task automatic t_disabled;
        write_period(3);
        check("R3 counter loaded when disabled", int'(dead_cnt), 3);
        pwm_in = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick();
            check("R2 quiet while disabled", int'({f0, f1, irq}), 0);
        end
    endtask

    task automatic t_enable;
        ctl_wr = 1'b1; ctl_enable = 1'b1;
        tick();
        ctl_wr = 1'b0;
        check("R10 still off at enable edge", int'({f0, f1}), 0);
        tick();
        finish_dead(1'b1, 3, 1'b0);   // R10
    endtask

    task automatic t_edges;
        edge_run(1'b0, 3, 1'b0);
        write_period(5);
        check("R4 counter kept on enabled write", int'(dead_cnt), 0);
        edge_run(1'b1, 5, 1'b0);
        write_period(0);
        edge_run(1'b0, 0, 1'b0);
    endtask

    task automatic t_restart;
        write_period(4);
        check("R4 counter kept on enabled write", int'(dead_cnt), 0);
        pwm_in = 1'b1;
        tick(); tick(); tick();
        check("R5 counting before restart", int'(dead_cnt), 2);
        edge_run(1'b0, 4, 1'b0);      // R5 restart mid-count
    endtask

    task automatic t_kill;
        kill_in = 1'b1;
        tick();
        check("R9 one-stage latency", int'(f1), 1);
        tick();
        check("R9 kill takes effect", int'(f1), 0);
        edge_run(1'b1, 4, 1'b1);      // R9 counting and irq continue
        kill_in = 1'b0;
        tick();
        check("R9 release latency", int'(f0), 0);
        tick();
        check("R9 drive resumes", int'(f0), 1);
    endtask

    task automatic t_disable_mid;
        pwm_in = 1'b0;
        tick(); tick();
        check("R11 counting", int'(dead_cnt), 3);
        ctl_wr = 1'b1; ctl_enable = 1'b0;
        tick();
        ctl_wr = 1'b0;
        check("R11 last decrement", int'(dead_cnt), 2);
        for (int i = 0; i < 3; i++) begin
            pwm_in = ~pwm_in;
            tick();
            check("R11 counter frozen", int'(dead_cnt), 2);
            check("R2 quiet after disable", int'({f0, f1, irq}), 0);
        end
        write_period(7);
        check("R3 reload while disabled", int'(dead_cnt), 7);
    endtask

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_disabled();
        t_enable();
        t_edges();
        t_restart();
        t_kill();
        t_disable_mid();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule